// File: doc/BRIEF.md
# Barrel Shifter with Carry Generation

This block shifts or rotates a data word by a variable distance and produces the bit that falls off the end as a carry-out, the way a load/store RISC data path prepares the second operand of an ALU operation. Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and rotate right through carry by one place. For each kind the carry-out follows the rule that kind defines. If the result is zero-distance, the operand and the carry-in pass through unchanged.

The kind and distance can come from four sources, chosen by a select input. They can be given directly. They can be decoded from the immediate shift fields of an instruction word in either of two field layouts. Or they can be register-specified, where the distance is a full byte taken from a register. Immediate decoding applies the compact-encoding rules: a zero distance on a right shift stands for 32, and a zero distance on a rotate stands for rotate through carry. Illegal combinations clear a valid flag and force the result to zero. The datapath is combinational. A parameter adds one output register stage for timing work.

Top module: `shf_unit`

## Requirements
- R1: In direct mode (src_sel=0) kind_in selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry. The distance is amount_in. The codes 5 to 7 are illegal: valid=0, result=0, carry_out=0.
- R2: src_sel=1 takes the 5-bit distance from instr[11:7] and the type from instr[6:5]. src_sel=2 takes the distance from {instr[14:12],instr[7:6]} and the type from instr[5:4]. src_sel=3 (register mode) takes the type from kind_in[1:0] and the distance from amount_in. In register mode type 3 is always rotate right, even for distance 0.
- R3: In both immediate modes, type 0 is logical left, 1 logical right, 2 arithmetic right and 3 rotate right. For types 1 and 2 a distance field of 0 means a shift of 32.
- R4: In both immediate modes, type 3 with a distance field of 0 selects rotate through carry with a distance of 1.
- R5: With a distance of 0 and a legal kind other than rotate through carry, result equals operand and carry_out equals carry_in.
- R6: Logical left by n: for n<32 the result is operand<<n and the carry is operand bit (32-n). For n=32 the result is 0 and the carry is operand bit 0. For n>32 both are 0.
- R7: Logical right by n: for n<32 the result is operand>>n and the carry is operand bit (n-1). For n=32 the result is 0 and the carry is operand bit 31. For n>32 both are 0.
- R8: Arithmetic right by n<32 shifts in copies of bit 31, and the carry is operand bit (n-1). For n>=32 every result bit and the carry equal operand bit 31.
- R9: Rotate right uses n modulo 32. The carry is bit 31 of the rotated result.
- R10: Rotate through carry by 1 gives {carry_in, operand[31:1]} with carry_out = operand bit 0.
- R11: Rotate through carry with any distance other than 1 gives valid=0, result=0 and carry_out=0.
- R12: With REG_OUT=1 the outputs appear one clock after the inputs, and they are all zero while rst_n is low. With REG_OUT=0 the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low reset of the output stage |
| src_sel | input | 2 | Source of kind and distance: direct, wide immediate, split immediate, register |
| kind_in | input | 3 | Shift kind (direct mode) or type in bits 1:0 (register mode) |
| amount_in | input | 8 | Shift distance for direct and register modes |
| instr | input | 32 | Instruction word holding the immediate shift fields |
| operand | input | WIDTH | Data word to shift |
| carry_in | input | 1 | Incoming carry flag |
| result | output | WIDTH | Shifted word |
| carry_out | output | 1 | Bit shifted out, or carry_in for zero distance |
| valid | output | 1 | Low for an illegal kind/distance combination |

## Verification
The assertions check, on every clocked cycle, several whole-class properties. An illegal combination always yields a zero result and carry. Zero-distance passthrough holds. The rotate carry always matches the top result bit. Rotate through carry always moves carry_in into the top bit and bit 0 out. Long arithmetic shifts always fill with the sign. Immediate right shifts never decode to a zero distance. The registered stage lags the combinational value by one cycle. Exact bit positions can only be shown by the bench's directed scenarios. These cover carry positions at distances of 1, 32 and beyond 32, rotate modulo 32, and the field extraction of both instruction layouts against hand-computed words.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam logic [2:0] SK_LSL = 3'd0;
    localparam logic [2:0] SK_LSR = 3'd1;
    localparam logic [2:0] SK_ASR = 3'd2;
    localparam logic [2:0] SK_ROR = 3'd3;
    localparam logic [2:0] SK_RRX = 3'd4;

    localparam int AMT_W = 8;

    typedef enum logic [1:0] {
        SRC_DIRECT    = 2'd0,
        SRC_IMM_WIDE  = 2'd1,
        SRC_IMM_SPLIT = 2'd2,
        SRC_REG       = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [2:0]       kind;
        logic [AMT_W-1:0] amt;
    } shift_req_t;

    // Compact immediate rules: zero distance means 32 on right shifts,
    // and means one-place rotate through carry on type 3.
    function automatic shift_req_t imm_decode(input logic [1:0] ty, input logic [4:0] imm5);
        shift_req_t r;
        r.kind = {1'b0, ty};
        r.amt  = {3'b000, imm5};
        if (imm5 == 5'd0) begin
            case (ty)
                2'd1, 2'd2: r.amt = 8'd32;
                2'd3: begin
                    r.kind = SK_RRX;
                    r.amt  = 8'd1;
                end
                default: r.amt = 8'd0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/shf_decode.sv
module shf_decode
    import shf_pkg::*;
(
    input  logic [1:0]       src_sel,
    input  logic [2:0]       kind_in,
    input  logic [AMT_W-1:0] amount_in,
    input  logic [31:0]      instr,
    output shift_req_t       req
);
    logic [4:0] wide_imm5;
    logic [4:0] split_imm5;
    logic       unused_instr;

    assign wide_imm5    = instr[11:7];
    assign split_imm5   = {instr[14:12], instr[7:6]};
    assign unused_instr = ^{instr[31:15], instr[3:0]};

    always_comb begin
        req = '0;
        case (src_sel_e'(src_sel))
            SRC_DIRECT: begin
                req.kind = kind_in;
                req.amt  = amount_in;
            end
            SRC_IMM_WIDE:  req = imm_decode(instr[6:5], wide_imm5);
            SRC_IMM_SPLIT: req = imm_decode(instr[5:4], split_imm5);
            default: begin
                // register mode: type 3 is plain rotate regardless of distance
                req.kind = {1'b0, kind_in[1:0]};
                req.amt  = amount_in;
            end
        endcase
    end
endmodule

// File: rtl/shf_core.sv
module shf_core
    import shf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    input  shift_req_t       req,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ok
);
    localparam int LOG_W = $clog2(WIDTH);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

    logic [WIDTH:0]        lsl_w;
    logic [WIDTH:0]        lsr_w;
    logic signed [WIDTH:0] asr_w;
    logic [AMT_W-1:0]      asr_n;
    logic [LOG_W-1:0]      rot_n;
    logic [WIDTH-1:0]      rot_v;

    assign asr_n = (req.amt > FULL) ? FULL : req.amt;
    assign rot_n = req.amt[LOG_W-1:0];

    // one guard bit catches the carry; distances past the width clear it
    assign lsl_w = {1'b0, operand} << req.amt;
    assign lsr_w = {operand, 1'b0} >> req.amt;
    assign asr_w = $signed({operand, 1'b0}) >>> asr_n;
    assign rot_v = WIDTH'({operand, operand} >> rot_n);

    always_comb begin
        ok   = 1'b1;
        res  = '0;
        cout = 1'b0;
        if (req.kind == SK_RRX) begin
            if (req.amt == AMT_W'(1)) begin
                res  = {carry_in, operand[WIDTH-1:1]};
                cout = operand[0];
            end else begin
                ok = 1'b0;
            end
        end else if (req.kind > SK_RRX) begin
            ok = 1'b0;
        end else if (req.amt == '0) begin
            res  = operand;
            cout = carry_in;
        end else begin
            case (req.kind)
                SK_LSL: begin
                    res  = lsl_w[WIDTH-1:0];
                    cout = lsl_w[WIDTH];
                end
                SK_LSR: begin
                    res  = lsr_w[WIDTH:1];
                    cout = lsr_w[0];
                end
                SK_ASR: begin
                    res  = asr_w[WIDTH:1];
                    cout = asr_w[0];
                end
                default: begin
                    res  = rot_v;
                    cout = rot_v[WIDTH-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic [2:0]       kind_in,
    input  logic [7:0]       amount_in,
    input  logic [31:0]      instr,
    input  logic [WIDTH-1:0] operand,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             valid
);
    localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
        logic             ok;
    } shf_out_t;

    shift_req_t       dec_req;
    shf_out_t         out_d;
    logic [WIDTH-1:0] core_res;
    logic             core_cout;
    logic             core_ok;

    shf_decode u_decode (
        .src_sel   (src_sel),
        .kind_in   (kind_in),
        .amount_in (amount_in),
        .instr     (instr),
        .req       (dec_req)
    );

    shf_core #(.WIDTH(WIDTH)) u_core (
        .operand  (operand),
        .carry_in (carry_in),
        .req      (dec_req),
        .res      (core_res),
        .cout     (core_cout),
        .ok       (core_ok)
    );

    always_comb begin
        out_d.res  = core_res;
        out_d.cout = core_cout;
        out_d.ok   = core_ok;
    end

    generate
        if (REG_OUT) begin : g_stage
            shf_out_t out_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
            assign result    = out_q.res;
            assign carry_out = out_q.cout;
            assign valid     = out_q.ok;

            p_stage_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (valid == $past(out_d.ok) && result == $past(out_d.res)
                           && carry_out == $past(out_d.cout)));
        end else begin : g_comb
            assign result    = out_d.res;
            assign carry_out = out_d.cout;
            assign valid     = out_d.ok;
        end
    endgenerate

    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_d.ok |-> (out_d.res == '0 && !out_d.cout));

    p_zero_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req.kind <= SK_ROR && dec_req.amt == '0) |->
        (out_d.res == operand && out_d.cout == carry_in && out_d.ok));

    p_through_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req.kind == SK_RRX && dec_req.amt == AMT_W'(1)) |->
        (out_d.res[WIDTH-1] == carry_in && out_d.cout == operand[0]));

    p_rot_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req.kind == SK_ROR && dec_req.amt != '0) |->
        (out_d.cout == out_d.res[WIDTH-1]));

    p_sign_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req.kind == SK_ASR && dec_req.amt >= FULL) |->
        ($countones(out_d.res) == (operand[WIDTH-1] ? WIDTH : 0)
         && out_d.cout == operand[WIDTH-1]));

    p_imm_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel == 2'd1 || src_sel == 2'd2)
         && (dec_req.kind == SK_LSR || dec_req.kind == SK_ASR)) |->
        (dec_req.amt != '0 && dec_req.amt <= AMT_W'(32)));
endmodule

// File: tb/shf_unit_bench.sv
module shf_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [2:0]  kind_in = '0;
    logic [7:0]  amount_in = '0;
    logic [31:0] instr = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result, result_r;
    logic        carry_out, carry_out_r, valid, valid_r;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    shf_unit u_shf_unit (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .kind_in(kind_in),
        .amount_in(amount_in), .instr(instr), .operand(operand), .carry_in(carry_in),
        .result(result), .carry_out(carry_out), .valid(valid)
    );

    shf_unit #(.REG_OUT(1'b1)) u_shf_unit_reg (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .kind_in(kind_in),
        .amount_in(amount_in), .instr(instr), .operand(operand), .carry_in(carry_in),
        .result(result_r), .carry_out(carry_out_r), .valid(valid_r)
    );

    task automatic expect3(string tag, logic [31:0] r, logic c, logic v,
                           logic [31:0] er, logic ec, logic ev);
        checks++;
        if (r !== er || c !== ec || v !== ev) begin
            errors++;
            $display("FAIL %s: got res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                     tag, r, c, v, er, ec, ev);
        end
    endtask

    task automatic apply(logic [1:0] sel, logic [2:0] k, logic [7:0] n,
                         logic [31:0] iw, logic [31:0] op, logic ci);
        @(negedge clk);
        src_sel = sel; kind_in = k; amount_in = n; instr = iw; operand = op; carry_in = ci;
        #1;
    endtask

    task automatic t_reset;
        expect3("R12 reset", result_r, carry_out_r, valid_r, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_left;
        apply(2'd0, 3'd0, 8'd1, '0, 32'h8000_0001, 1'b0);
        expect3("R1 R6 lsl1", result, carry_out, valid, 32'h0000_0002, 1'b1, 1'b1);
        apply(2'd0, 3'd0, 8'd4, '0, 32'hF000_000F, 1'b0);
        expect3("R6 lsl4", result, carry_out, valid, 32'h0000_00F0, 1'b1, 1'b1);
        apply(2'd0, 3'd0, 8'd32, '0, 32'h0000_0001, 1'b0);
        expect3("R6 lsl32", result, carry_out, valid, 32'h0, 1'b1, 1'b1);
        apply(2'd0, 3'd0, 8'd33, '0, 32'hFFFF_FFFF, 1'b1);
        expect3("R6 lsl33", result, carry_out, valid, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_right;
        apply(2'd0, 3'd1, 8'd1, '0, 32'h8000_0003, 1'b0);
        expect3("R7 lsr1", result, carry_out, valid, 32'h4000_0001, 1'b1, 1'b1);
        apply(2'd0, 3'd1, 8'd32, '0, 32'h8000_0000, 1'b0);
        expect3("R7 lsr32", result, carry_out, valid, 32'h0, 1'b1, 1'b1);
        apply(2'd0, 3'd1, 8'd40, '0, 32'hFFFF_FFFF, 1'b1);
        expect3("R7 lsr40", result, carry_out, valid, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_arith;
        apply(2'd0, 3'd2, 8'd4, '0, 32'h8000_0010, 1'b1);
        expect3("R8 asr4", result, carry_out, valid, 32'hF800_0001, 1'b0, 1'b1);
        apply(2'd0, 3'd2, 8'd5, '0, 32'h8000_0010, 1'b0);
        expect3("R8 asr5", result, carry_out, valid, 32'hFC00_0000, 1'b1, 1'b1);
        apply(2'd0, 3'd2, 8'd32, '0, 32'h8000_0000, 1'b0);
        expect3("R8 asr32", result, carry_out, valid, 32'hFFFF_FFFF, 1'b1, 1'b1);
        apply(2'd0, 3'd2, 8'd200, '0, 32'h7FFF_FFFF, 1'b1);
        expect3("R8 asr200", result, carry_out, valid, 32'h0, 1'b0, 1'b1);
    endtask

    task automatic t_rotate;
        apply(2'd0, 3'd3, 8'd1, '0, 32'h0000_0001, 1'b0);
        expect3("R9 ror1", result, carry_out, valid, 32'h8000_0000, 1'b1, 1'b1);
        apply(2'd0, 3'd3, 8'd36, '0, 32'h0000_00F0, 1'b1);
        expect3("R9 ror36", result, carry_out, valid, 32'h0000_000F, 1'b0, 1'b1);
        apply(2'd0, 3'd3, 8'd32, '0, 32'h8000_0000, 1'b0);
        expect3("R9 ror32", result, carry_out, valid, 32'h8000_0000, 1'b1, 1'b1);
    endtask

    task automatic t_through_carry;
        apply(2'd0, 3'd4, 8'd1, '0, 32'h0000_0003, 1'b1);
        expect3("R10 rrx", result, carry_out, valid, 32'h8000_0001, 1'b1, 1'b1);
        apply(2'd0, 3'd4, 8'd0, '0, 32'hFFFF_FFFF, 1'b1);
        expect3("R11 rrx amt0", result, carry_out, valid, 32'h0, 1'b0, 1'b0);
        apply(2'd0, 3'd4, 8'd2, '0, 32'hFFFF_FFFF, 1'b1);
        expect3("R11 rrx amt2", result, carry_out, valid, 32'h0, 1'b0, 1'b0);
        apply(2'd0, 3'd6, 8'd3, '0, 32'hFFFF_FFFF, 1'b1);
        expect3("R1 kind6 illegal", result, carry_out, valid, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_zero;
        apply(2'd0, 3'd0, 8'd0, '0, 32'h1234_5678, 1'b1);
        expect3("R5 lsl0", result, carry_out, valid, 32'h1234_5678, 1'b1, 1'b1);
        apply(2'd0, 3'd1, 8'd0, '0, 32'hFFFF_FFFF, 1'b0);
        expect3("R5 lsr0", result, carry_out, valid, 32'hFFFF_FFFF, 1'b0, 1'b1);
    endtask

    task automatic t_wide_imm;
        apply(2'd1, 3'd7, 8'd9, 32'h0000_0020, 32'h8000_0000, 1'b0);
        expect3("R2 R3 wide lsr#0=32", result, carry_out, valid, 32'h0, 1'b1, 1'b1);
        apply(2'd1, 3'd0, 8'd0, 32'h0000_0040, 32'h8000_0000, 1'b0);
        expect3("R3 wide asr#0=32", result, carry_out, valid, 32'hFFFF_FFFF, 1'b1, 1'b1);
        apply(2'd1, 3'd0, 8'd0, 32'h0000_0200, 32'h0000_0001, 1'b0);
        expect3("R2 wide lsl4", result, carry_out, valid, 32'h0000_0010, 1'b0, 1'b1);
        apply(2'd1, 3'd0, 8'd0, 32'h0000_0060, 32'h0000_0002, 1'b1);
        expect3("R4 wide rrx", result, carry_out, valid, 32'h8000_0001, 1'b0, 1'b1);
    endtask

    task automatic t_split_imm;
        apply(2'd2, 3'd0, 8'd0, 32'h0000_2030, 32'h0000_00AB, 1'b0);
        expect3("R2 split ror8", result, carry_out, valid, 32'hAB00_0000, 1'b1, 1'b1);
        apply(2'd2, 3'd0, 8'd0, 32'h0000_0050, 32'h0000_0003, 1'b0);
        expect3("R2 split lsr1", result, carry_out, valid, 32'h0000_0001, 1'b1, 1'b1);
        apply(2'd2, 3'd0, 8'd0, 32'h0000_0030, 32'h0000_0001, 1'b0);
        expect3("R4 split rrx", result, carry_out, valid, 32'h0, 1'b1, 1'b1);
    endtask

    task automatic t_register;
        apply(2'd3, 3'd3, 8'd0, 32'h0000_0060, 32'hCAFE_0001, 1'b1);
        expect3("R2 R5 reg ror0", result, carry_out, valid, 32'hCAFE_0001, 1'b1, 1'b1);
        apply(2'd3, 3'd7, 8'd4, 32'h0, 32'h0000_000F, 1'b0);
        expect3("R2 reg ror4", result, carry_out, valid, 32'hF000_0000, 1'b1, 1'b1);
    endtask

    task automatic t_stage;
        apply(2'd0, 3'd0, 8'd1, '0, 32'h0000_0001, 1'b0);
        @(posedge clk); #1;
        expect3("R12 staged", result_r, carry_out_r, valid_r, 32'h0000_0002, 1'b0, 1'b1);
        @(negedge clk);
        operand = 32'h0000_0004;
        #1;
        expect3("R12 holds until edge", result_r, carry_out_r, valid_r, 32'h0000_0002, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_left();
        t_right();
        t_arith();
        t_rotate();
        t_through_carry();
        t_zero();
        t_wide_imm();
        t_split_imm();
        t_register();
        t_stage();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule